// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits next to a simple sequential processor core and decides when the core's normal fetch-execute flow is diverted into an interrupt handler. It merges the completion flags of a parameterised set of devices into a single interrupt request. It tests that request only at instruction boundaries, marked by a retire strobe from the core, and only while an interrupt-enable flag is set.

When an interrupt is taken, the block clears the enable flag and stalls the core. It writes the core's current program counter to memory word 0. The core has already advanced that counter past the finished instruction. The block then reads memory word 1 and pulses a PC load with the value it read. Software re-arms interrupts with an enable-set pulse once the handler is ready for more.

The memory port is a request/ready handshake. The block raises `mem_req` and holds `mem_addr`, `mem_we` and `mem_wdata` unchanged until it samples `mem_ready` high at a clock edge. For a read, `mem_rdata` is taken in that same accepting cycle. The memory may hold `mem_ready` low for any number of cycles, and the sequence simply waits. All other pins are plain level or single-cycle strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: The interrupt request is the OR of all `dev_done` bits: any single bit, at any index, can cause entry, and with every bit low no entry occurs.
- R2: Entry is decided only in a cycle where `retire` is high. A pending, enabled request without `retire` leaves `stall` low.
- R3: While `irq_en` is 0, no entry occurs, whatever `dev_done` and `retire` do.
- R4: On entry, `irq_en` reads 0 from the cycle after the accepting edge. While it stays 0, a still-pending request plus `retire` causes no second entry.
- R5: The first memory transfer of an entry is a write (`mem_we`=1) to address 0, carrying the `pc_in` value present with the accepted `retire`.
- R6: The second transfer is a read (`mem_we`=0) from address 1. In the cycle after that read is accepted, `pc_load` is 1 for exactly one cycle and `pc_load_val` equals the data that was read.
- R7: While `mem_req` is 1 and `mem_ready` is 0, the request and its address, direction and write data stay unchanged, and the sequence does not advance.
- R8: `stall` is 1 from the cycle after the accepting edge through the `pc_load` cycle, and 0 in the cycle after it.
- R9: While `halt` is 1, `fetch_en` is 0 and no entry occurs. Otherwise `fetch_en` is the inverse of `stall`.
- R10: An `ien_set` pulse makes `irq_en` 1 in the next cycle. If it coincides with an accepted entry, the entry wins and `irq_en` ends at 0.
- R11: After reset, `irq_en`, `stall`, `mem_req` and `pc_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_done | input | N_DEV | Level completion flags, one per device |
| retire | input | 1 | Core finished an instruction this cycle |
| pc_in | input | ADDR_W | Core PC, already incremented past the retired instruction |
| halt | input | 1 | Stops fetching and suppresses entry |
| ien_set | input | 1 | Software pulse that sets the interrupt-enable flag |
| irq_en | output | 1 | Current interrupt-enable flag |
| stall | output | 1 | Holds the core during the entry sequence |
| fetch_en | output | 1 | Core may fetch the next instruction |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid in the accepting cycle |
| pc_load | output | 1 | One-cycle strobe to load a new PC |
| pc_load_val | output | ADDR_W | Handler address to load |

## Verification
The bench drives inputs on the falling edge and reads outputs on the next falling edge, so every registered result is checked exactly one clock after the edge that caused it. The clear of `irq_en`, the rise of `stall` and the save write all appear one cycle after the accepting `retire`. The vector read appears one cycle after the write is accepted, and `pc_load` appears one cycle after the read is accepted. Memory wait states are inserted by holding `mem_ready` low for a chosen count, and the bench rechecks the held request on every one of those cycles. Conditions that must cause no entry are checked by watching `stall` and `mem_req` for several cycles afterwards.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_SAVE = 2'd1,
    ENT_VEC  = 2'd2,
    ENT_LOAD = 2'd3
  } ent_state_t;
endpackage

// File: rtl/irq_req_merge.sv
module irq_req_merge #(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV-1:0] done_i,
  output logic             req_o
);
  logic [N_DEV:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_DEV; g++) begin : g_or
    assign chain[g+1] = chain[g] | done_i[g];
  end
  assign req_o = chain[N_DEV];
endmodule

// File: rtl/irq_enable_flag.sv
module irq_enable_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  // Clear has priority: an entry in the same cycle as a set leaves it off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_o <= 1'b0;
    else if (clr_i) en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              busy_o,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val
);
  localparam logic [ADDR_W-1:0] SAVE_WORD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] VEC_WORD  = ADDR_W'(1);

  ent_state_t        state, state_nx;
  logic [ADDR_W-1:0] ret_pc;
  logic [ADDR_W-1:0] vec_pc;

  always_comb begin
    state_nx = state;
    case (state)
      ENT_IDLE: if (take_i)    state_nx = ENT_SAVE;
      ENT_SAVE: if (mem_ready) state_nx = ENT_VEC;
      ENT_VEC:  if (mem_ready) state_nx = ENT_LOAD;
      ENT_LOAD:                state_nx = ENT_IDLE;
      default:                 state_nx = ENT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ENT_IDLE;
      ret_pc <= '0;
      vec_pc <= '0;
    end else begin
      state <= state_nx;
      if (state == ENT_IDLE && take_i)   ret_pc <= pc_i;
      if (state == ENT_VEC && mem_ready) vec_pc <= ADDR_W'(mem_rdata);
    end
  end

  assign busy_o      = (state != ENT_IDLE);
  assign mem_req     = (state == ENT_SAVE) || (state == ENT_VEC);
  assign mem_we      = (state == ENT_SAVE);
  assign mem_addr    = (state == ENT_VEC) ? VEC_WORD : SAVE_WORD;
  assign mem_wdata   = DATA_W'(ret_pc);
  assign pc_load     = (state == ENT_LOAD);
  assign pc_load_val = vec_pc;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int N_DEV  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DEV-1:0]  dev_done,
  input  logic              retire,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              halt,
  input  logic              ien_set,
  output logic              irq_en,
  output logic              stall,
  output logic              fetch_en,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_load_val
);
  logic irq_req;
  logic take;
  logic busy;

  irq_req_merge #(.N_DEV(N_DEV)) u_merge (
    .done_i (dev_done),
    .req_o  (irq_req)
  );

  assign take = irq_req & irq_en & retire & ~halt & ~busy;

  irq_enable_flag u_ien (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ien_set),
    .clr_i (take),
    .en_o  (irq_en)
  );

  irq_entry_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .pc_i        (pc_in),
    .busy_o      (busy),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .pc_load     (pc_load),
    .pc_load_val (pc_load_val)
  );

  assign stall    = busy;
  assign fetch_en = ~halt & ~busy;
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int N_DEV  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_DEV-1:0]  dev_done,
  input logic              retire,
  input logic              halt,
  input logic              ien_set,
  input logic              irq_en,
  input logic              stall,
  input logic              fetch_en,
  input logic              mem_req,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              pc_load
);
  assert_entry_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(retire && (|dev_done) && irq_en && !halt));

  assert_ien_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> !irq_en);

  assert_save_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == ADDR_W'(0)));

  assert_vec_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr == ADDR_W'(1)));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

  assert_load_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !stall);

  assert_halt_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !fetch_en);

  assert_halt_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !stall) |=> !stall);

  assert_ien_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !(retire && (|dev_done) && irq_en && !halt && !stall)) |=> irq_en);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .dev_done  (dev_done),
  .retire    (retire),
  .halt      (halt),
  .ien_set   (ien_set),
  .irq_en    (irq_en),
  .stall     (stall),
  .fetch_en  (fetch_en),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .pc_load   (pc_load)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  localparam int N_DEV  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_DEV-1:0]  dev_done = '0;
  logic              retire = 1'b0;
  logic [ADDR_W-1:0] pc_in = '0;
  logic              halt = 1'b0;
  logic              ien_set = 1'b0;
  logic              irq_en, stall, fetch_en, mem_req, mem_we, pc_load;
  logic              mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr, pc_load_val;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_entry_seq #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .dev_done(dev_done), .retire(retire), .pc_in(pc_in),
    .halt(halt), .ien_set(ien_set), .irq_en(irq_en), .stall(stall), .fetch_en(fetch_en),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_load(pc_load),
    .pc_load_val(pc_load_val)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic arm();
    ien_set = 1'b1; tick(); ien_set = 1'b0;
  endtask

  // Drive retire for one cycle, then confirm no entry for a few cycles.
  task automatic expect_no_entry(input string tag);
    retire = 1'b1; tick(); retire = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(stall == 1'b0, tag, stall, 0);
      check(mem_req == 1'b0, tag, mem_req, 0);
      tick();
    end
  endtask

  // Full entry with a given number of wait states per memory transfer.
  task automatic run_entry(input logic [ADDR_W-1:0] pc, input logic [DATA_W-1:0] vec,
                           input int waits, input bit set_too);
    pc_in = pc; retire = 1'b1; ien_set = set_too;
    tick();
    retire = 1'b0; ien_set = 1'b0; pc_in = '0;
    check(stall == 1'b1, "R8 stall after entry", stall, 1);
    check(irq_en == 1'b0, set_too ? "R10 entry wins over set" : "R4 enable cleared", irq_en, 0);
    for (int w = 0; w <= waits; w++) begin
      check(mem_req && mem_we, "R5 save is write", {mem_req, mem_we}, 3);
      check(mem_addr == 0, "R5 save address", mem_addr, 0);
      check(mem_wdata == DATA_W'(pc), "R5 saved pc", mem_wdata, pc);
      if (w > 0) check(stall == 1'b1, "R7 held while waiting", stall, 1);
      if (w == waits) mem_ready = 1'b1;
      tick();
      mem_ready = 1'b0;
    end
    for (int w = 0; w <= waits; w++) begin
      check(mem_req && !mem_we, "R6 vector is read", {mem_req, mem_we}, 2);
      check(mem_addr == 1, "R6 vector address", mem_addr, 1);
      check(pc_load == 1'b0, "R7 no load before ready", pc_load, 0);
      if (w == waits) begin mem_ready = 1'b1; mem_rdata = vec; end
      tick();
      mem_ready = 1'b0; mem_rdata = '0;
    end
    check(pc_load == 1'b1, "R6 pc_load pulse", pc_load, 1);
    check(pc_load_val == ADDR_W'(vec), "R6 loaded vector", pc_load_val, vec);
    check(stall == 1'b1, "R8 stall during load", stall, 1);
    check(mem_req == 1'b0, "R6 no third transfer", mem_req, 0);
    tick();
    check(pc_load == 1'b0, "R6 single-cycle load", pc_load, 0);
    check(stall == 1'b0, "R8 stall released", stall, 0);
    check(fetch_en == 1'b1, "R9 fetch resumes", fetch_en, 1);
  endtask

  task automatic t_reset();
    check(irq_en == 1'b0, "R11 irq_en reset", irq_en, 0);
    check(stall == 1'b0, "R11 stall reset", stall, 0);
    check(mem_req == 1'b0, "R11 mem_req reset", mem_req, 0);
    check(pc_load == 1'b0, "R11 pc_load reset", pc_load, 0);
    check(fetch_en == 1'b1, "R9 fetch_en idle", fetch_en, 1);
  endtask

  task automatic t_disabled();
    dev_done = 4'b0010;
    expect_no_entry("R3 disabled no entry");
    dev_done = '0;
  endtask

  task automatic t_set();
    arm();
    check(irq_en == 1'b1, "R10 set takes effect", irq_en, 1);
  endtask

  task automatic t_no_retire();
    dev_done = 4'b0100;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(stall == 1'b0, "R2 no entry without retire", stall, 0);
    end
    dev_done = '0;
  endtask

  task automatic t_none_pending();
    expect_no_entry("R1 no request no entry");
    check(irq_en == 1'b1, "R1 enable kept", irq_en, 1);
  endtask

  task automatic t_entry_dev0();
    dev_done = 4'b0001;
    run_entry(16'h1235, 16'h0400, 0, 1'b0);
    expect_no_entry("R4 masked after entry");
    check(irq_en == 1'b0, "R4 still masked", irq_en, 0);
    dev_done = '0;
  endtask

  task automatic t_entry_top_waits();
    arm();
    dev_done = 4'b1000;
    run_entry(16'hBEEF, 16'h0A5A, 3, 1'b0);
    dev_done = '0;
  endtask

  task automatic t_halt();
    arm();
    dev_done = 4'b0001;
    halt = 1'b1;
    tick();
    check(fetch_en == 1'b0, "R9 halt blocks fetch", fetch_en, 0);
    expect_no_entry("R9 halt blocks entry");
    halt = 1'b0;
    tick();
    check(fetch_en == 1'b1, "R9 fetch after halt", fetch_en, 1);
    check(irq_en == 1'b1, "R9 enable untouched", irq_en, 1);
    dev_done = '0;
  endtask

  task automatic t_set_collision();
    dev_done = 4'b0110;
    run_entry(16'h0042, 16'h7777, 1, 1'b1);
    check(irq_en == 1'b0, "R10 cleared after collision", irq_en, 0);
    dev_done = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_disabled();
    t_set();
    t_no_retire();
    t_none_pending();
    t_entry_dev0();
    t_entry_top_waits();
    t_halt();
    t_set_collision();
    tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule